// File: doc/BRIEF.md
# Serial Audio Frame Formatter

This block turns one stereo pair of 16-bit samples, plus a small group of status flags, into a framed bit stream for a serial audio port. Each cycle of the block clock is one bit period. For every period the block drives a serial data bit, a clock enable that tells the port whether a serial clock edge is issued in that period, and a frame-sync flag.

A 2-bit format select picks one of four frame layouts. Two layouts are 64 clocked periods long: one carries a status word and one carries only samples. The third is 32 clocked sample periods followed by 32 periods with no clock. The fourth is a short 32-period frame with only the two samples.

Samples, flags and the format select are sampled once, at each frame boundary. Changes made during a frame therefore apply to the next frame. Data goes out most significant bit first. The frame-sync flag marks the period just before the first bit of every frame.

Top module: `serial_frame_fmt`

## Requirements
- R1: While reset is held, fsync reads 1, sclkEn reads 1 and sdata reads 0. The first frame begins in the period after the first clock edge at which reset is low.
- R2: With format 00 or 01, a frame is 64 periods long and sclkEn is high in all of them. Periods 0 to 15 carry the left word and periods 16 to 31 carry the right word, each most significant bit first.
- R3: With format 00, periods 32 to 38 are 0, period 39 is the interrupt flag, period 40 is capture enable, period 41 is playback enable, period 42 is overrange, and periods 43 to 63 are 0.
- R4: The overrange bit sent in period 42 is the OR of the left and the right overrange inputs.
- R5: With format 01, periods 32 to 63 are 0 whatever the status inputs are.
- R6: With format 10, periods 0 to 31 are clocked and carry data as in R2. Periods 32 to 63 have sclkEn low and sdata low.
- R7: With format 11, a frame is 32 periods long and every period is clocked. It carries left then right as in R2, with no gap.
- R8: fsync is high in exactly the last period of every frame and low in all other periods. Frames are therefore 32 or 64 periods apart, and the clock only resumes after a gap at the start of a frame.
- R9: The samples and status inputs are taken at the frame boundary. A change to them in the middle of a frame does not alter that frame and appears in the next frame.
- R10: The format select is taken at the frame boundary. A change in the middle of a frame leaves that frame's length, clocking and layout unchanged, and the new format applies from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one bit period per cycle |
| rst | input | 1 | Synchronous reset, active high |
| fmtSel | input | 2 | Frame format: 00 full with status, 01 samples only, 10 with unclocked gap, 11 short |
| leftWord | input | 16 | Left sample |
| rightWord | input | 16 | Right sample |
| irqFlag | input | 1 | Interrupt status flag |
| capEnable | input | 1 | Capture enable status flag |
| playEnable | input | 1 | Playback enable status flag |
| ovrLeft | input | 1 | Left channel over range |
| ovrRight | input | 1 | Right channel over range |
| sclkEn | output | 1 | High when a serial clock is issued this period |
| fsync | output | 1 | Frame sync, high in the period before a frame |
| sdata | output | 1 | Serial data bit for this period |

## Verification
The bench goes after the points where a wrong formatter would still look nearly right:
- The sample edges at periods 15/16 and 31/32. An off-by-one shift there smears the left word's last bit into the right word.
- The four flag slots. An inverted order or a one-place slip puts capture enable where the interrupt should be.
- Overrange driven from each channel alone. A design that forwards only one side drops the other.
- The gap in format 10. Clocking it, or leaving stale data in it, shows up on sclkEn or sdata.
- Mid-frame updates to the samples and to the format. A design that loads them early sends a torn frame or cuts a 64-period frame down to 32.
- Switches between 32- and 64-period formats. A wrong length moves the fsync pulse.

// File: rtl/sfmt_pkg.sv
`timescale 1ns/1ps
package sfmt_pkg;

  typedef enum logic [1:0] {
    FMT_FULL   = 2'b00,
    FMT_PLAIN  = 2'b01,
    FMT_GAPPED = 2'b10,
    FMT_SHORT  = 2'b11
  } fmt_e;

  typedef struct packed {
    logic load;
    logic shift;
  } strobe_t;

endpackage

// File: rtl/sfmt_ctrl.sv
`timescale 1ns/1ps
module sfmt_ctrl
  import sfmt_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] fmtSel,
  output strobe_t    strobe,
  output logic       sclkEn,
  output logic       fsync
);
  localparam int HALF_W = 2 * SAMPLE_W;
  localparam int FULL_W = 4 * SAMPLE_W;
  localparam int CNT_W  = $clog2(FULL_W);
  localparam logic [CNT_W-1:0] LAST_FULL = CNT_W'(FULL_W - 1);
  localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(HALF_W - 1);
  localparam logic [CNT_W-1:0] GAP_START = CNT_W'(HALF_W);

  logic [CNT_W-1:0] period;
  fmt_e             curFmt;
  logic [CNT_W-1:0] lastIdx;
  logic             atEnd;

  always_comb begin
    lastIdx = (curFmt == FMT_SHORT) ? LAST_HALF : LAST_FULL;
    atEnd   = (period == lastIdx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period <= LAST_FULL;
      curFmt <= FMT_FULL;
    end else if (atEnd) begin
      period <= '0;
      curFmt <= fmt_e'(fmtSel);
    end else begin
      period <= period + 1'b1;
    end
  end

  always_comb begin
    strobe.load  = atEnd;
    strobe.shift = !atEnd;
    fsync        = atEnd;
    sclkEn       = !((curFmt == FMT_GAPPED) && (period >= GAP_START));
  end

endmodule

// File: rtl/sfmt_dp.sv
`timescale 1ns/1ps
module sfmt_dp
  import sfmt_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int PAD_LEAD = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  strobe_t             strobe,
  input  logic [1:0]          fmtSel,
  input  logic [SAMPLE_W-1:0] leftWord,
  input  logic [SAMPLE_W-1:0] rightWord,
  input  logic                irqFlag,
  input  logic                capEnable,
  input  logic                playEnable,
  input  logic                ovrLeft,
  input  logic                ovrRight,
  output logic                sdata
);
  localparam int HALF_W   = 2 * SAMPLE_W;
  localparam int FULL_W   = 4 * SAMPLE_W;
  localparam int FLAG_N   = 4;
  localparam int PAD_TAIL = HALF_W - PAD_LEAD - FLAG_N;

  logic [HALF_W-1:0] statusBlk;
  logic [HALF_W-1:0] upperHalf;
  logic [FULL_W-1:0] frameWord;
  logic [FULL_W-1:0] shiftReg;

  always_comb begin
    statusBlk = {{PAD_LEAD{1'b0}}, irqFlag, capEnable, playEnable,
                 (ovrLeft | ovrRight), {PAD_TAIL{1'b0}}};
    upperHalf = (fmt_e'(fmtSel) == FMT_FULL) ? statusBlk : '0;
    frameWord = {leftWord, rightWord, upperHalf};
  end

  always_ff @(posedge clk) begin
    if (rst)               shiftReg <= '0;
    else if (strobe.load)  shiftReg <= frameWord;
    else if (strobe.shift) shiftReg <= {shiftReg[FULL_W-2:0], 1'b0};
  end

  assign sdata = shiftReg[FULL_W-1];

endmodule

// File: rtl/serial_frame_fmt.sv
`timescale 1ns/1ps
module serial_frame_fmt
  import sfmt_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          fmtSel,
  input  logic [SAMPLE_W-1:0] leftWord,
  input  logic [SAMPLE_W-1:0] rightWord,
  input  logic                irqFlag,
  input  logic                capEnable,
  input  logic                playEnable,
  input  logic                ovrLeft,
  input  logic                ovrRight,
  output logic                sclkEn,
  output logic                fsync,
  output logic                sdata
);
  strobe_t strobe;

  sfmt_ctrl #(.SAMPLE_W(SAMPLE_W)) i_ctrl (
    .clk(clk), .rst(rst), .fmtSel(fmtSel),
    .strobe(strobe), .sclkEn(sclkEn), .fsync(fsync)
  );

  sfmt_dp #(.SAMPLE_W(SAMPLE_W)) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .fmtSel(fmtSel),
    .leftWord(leftWord), .rightWord(rightWord),
    .irqFlag(irqFlag), .capEnable(capEnable), .playEnable(playEnable),
    .ovrLeft(ovrLeft), .ovrRight(ovrRight), .sdata(sdata)
  );

endmodule

// File: rtl/sfmt_checker.sv
`timescale 1ns/1ps
module sfmt_checker (
  input logic clk,
  input logic rst,
  input logic sclkEn,
  input logic fsync,
  input logic sdata
);
  logic [6:0] posCnt;

  always_ff @(posedge clk) begin
    if (rst)        posCnt <= 7'd63;
    else if (fsync) posCnt <= '0;
    else            posCnt <= posCnt + 1'b1;
  end

  a_r8_one_wide: assert property (@(posedge clk) disable iff (rst)
    fsync |=> !fsync);

  a_r8_frame_len: assert property (@(posedge clk) disable iff (rst)
    fsync |-> (posCnt == 7'd31 || posCnt == 7'd63));

  a_r6_gap_silent: assert property (@(posedge clk) disable iff (rst)
    !sclkEn |-> !sdata);

  a_r6_gap_late: assert property (@(posedge clk) disable iff (rst)
    !sclkEn |-> (posCnt >= 7'd32));

  a_r8_clock_resumes: assert property (@(posedge clk) disable iff (rst)
    $rose(sclkEn) |-> $past(fsync));

endmodule

bind serial_frame_fmt sfmt_checker i_chk (
  .clk(clk), .rst(rst), .sclkEn(sclkEn), .fsync(fsync), .sdata(sdata)
);

// File: tb/test_serial_frame_fmt.sv
`timescale 1ns/1ps
module test_serial_frame_fmt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  fmtSel = 2'b00;
  logic [15:0] leftWord = '0, rightWord = '0;
  logic        irqFlag = 1'b0, capEnable = 1'b0, playEnable = 1'b0;
  logic        ovrLeft = 1'b0, ovrRight = 1'b0;
  logic        sclkEn, fsync, sdata;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  serial_frame_fmt i_serial_frame_fmt (
    .clk(clk), .rst(rst), .fmtSel(fmtSel), .leftWord(leftWord),
    .rightWord(rightWord), .irqFlag(irqFlag), .capEnable(capEnable),
    .playEnable(playEnable), .ovrLeft(ovrLeft), .ovrRight(ovrRight),
    .sclkEn(sclkEn), .fsync(fsync), .sdata(sdata)
  );

  // vector: {fmt[1:0], left[15:0], right[15:0], st[4:0]}; st = {irq,cap,play,ovrL,ovrR}
  localparam logic [38:0] VEC [8] = '{
    {2'b00, 16'hA5C3, 16'h3C5A, 5'b10100},
    {2'b00, 16'h8001, 16'hFFFF, 5'b01010},
    {2'b00, 16'h0000, 16'h0000, 5'b00101},
    {2'b01, 16'h1234, 16'hFEDC, 5'b11111},
    {2'b10, 16'hBEEF, 16'h0F0F, 5'b11111},
    {2'b11, 16'hCAFE, 16'h7001, 5'b11111},
    {2'b11, 16'h0001, 16'h8000, 5'b00000},
    {2'b00, 16'hFFFF, 16'h0001, 5'b00110}
  };

  // Expected {clockEnable, dataBit} for period idx, built from R2..R7
  function automatic logic [1:0] expBits(input logic [1:0] f, input logic [15:0] l,
                                         input logic [15:0] r, input logic [4:0] st,
                                         input int idx);
    logic d;
    logic en;
    en = !(f == 2'b10 && idx >= 32);
    if (idx < 16)       d = l[15-idx];
    else if (idx < 32)  d = r[31-idx];
    else if (f != 2'b00) d = 1'b0;
    else if (idx == 39) d = st[4];
    else if (idx == 40) d = st[3];
    else if (idx == 41) d = st[2];
    else if (idx == 42) d = st[1] | st[0];
    else                d = 1'b0;
    return {en, d};
  endfunction

  task automatic check(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b exp %b", req, what, got, exp);
    end
  endtask

  // Called at a negedge where fsync is high; drives inputs and checks the next frame.
  task automatic runFrame(input string req, input logic [1:0] f, input logic [15:0] l,
                          input logic [15:0] r, input logic [4:0] st,
                          input bit doChange, input logic [1:0] cf, input logic [15:0] cl,
                          input logic [15:0] cr, input logic [4:0] cst);
    int len;
    logic [1:0] e;
    fmtSel = f; leftWord = l; rightWord = r;
    {irqFlag, capEnable, playEnable, ovrLeft, ovrRight} = st;
    len = (f == 2'b11) ? 32 : 64;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      e = expBits(f, l, r, st, i);
      check(req, $sformatf("sclkEn p%0d", i), sclkEn, e[1]);
      check(req, $sformatf("sdata p%0d", i), sdata, e[0]);
      check("R8", $sformatf("fsync p%0d", i), fsync, (i == len - 1));
      if (doChange && i == 10) begin
        fmtSel = cf; leftWord = cl; rightWord = cr;
        {irqFlag, capEnable, playEnable, ovrLeft, ovrRight} = cst;
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset fsync", fsync, 1'b1);
    check("R1", "reset sclkEn", sclkEn, 1'b1);
    check("R1", "reset sdata", sdata, 1'b0);
    rst = 1'b0;
    // R1: first frame starts right after reset release
    runFrame("R1 R2", 2'b00, 16'h9C31, 16'h4E72, 5'b11000, 0, 2'b00, '0, '0, '0);
    // table walk: R2 R3 R4 R5 R6 R7
    for (int k = 0; k < 8; k++) begin
      runFrame("R2 R3 R4 R5 R6 R7", VEC[k][38:37], VEC[k][36:21], VEC[k][20:5],
               VEC[k][4:0], 0, 2'b00, '0, '0, '0);
    end
    // R9 R10: mid-frame change of samples, flags and format is deferred
    runFrame("R9 R10", 2'b00, 16'h1357, 16'h2468, 5'b10100,
             1, 2'b11, 16'hFACE, 16'h0BAD, 5'b01011);
    runFrame("R9 R10", 2'b11, 16'hFACE, 16'h0BAD, 5'b01011, 0, 2'b00, '0, '0, '0);
    // R10: short frame changed to gapped mid-frame stays short
    runFrame("R10", 2'b11, 16'h8421, 16'h1248, 5'b00000,
             1, 2'b10, 16'h5555, 16'hAAAA, 5'b11111);
    runFrame("R6 R10", 2'b10, 16'h5555, 16'hAAAA, 5'b11111, 0, 2'b00, '0, '0, '0);
    // R4: right-only overrange after a gapped frame
    runFrame("R4", 2'b00, 16'h0000, 16'h0000, 5'b00001, 0, 2'b00, '0, '0, '0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule